// File: doc/BRIEF.md
# Locked Event Timestamp Capture

This block records the time at which a transmit or a receive timing event happens. A free-running time source supplies a 64-bit time value, split into a high and a low 32-bit word. When a channel's event strobe is seen, the block copies that time into the channel's stamp register and sets the channel's valid flag.

There are two channels, one for transmit and one for receive. Each channel has its own enable bit. Once a channel holds a stamp, it is locked: further events on that channel are dropped, so at most one stamp waits for software at a time. Software reads the low word first and then the high word. Reading the high word is what releases the lock, and it works whether or not the low word was read first. A new transmit stamp can also pulse an interrupt cause, subject to a mask bit.

The stamp words are continuous outputs. A read of the low word therefore has no side effect, and only the high-word read strobes reach the block.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset, both enable bits, both valid flags, both stamps and the interrupt output are 0.
- R2: While a channel's enable bit is 0, an event on that channel sets no valid flag and leaves the stamp unchanged.
- R3: An enabled, unlocked channel that sees an event in a cycle shows valid = 1 after the next rising edge. Its stamp then equals the time input sampled at that edge, with the high word on the `_hi` port and the low word on the `_lo` port.
- R4: While a channel's valid flag is 1, later events on that channel leave the stamp and the flag unchanged.
- R5: A high-word read strobe on a channel clears that channel's valid flag at the next edge, whether or not the low word was read, and re-arms the channel for the next event.
- R6: An event that arrives in the same cycle as a high-word read strobe on that channel is dropped: valid reads 0 afterwards and the stamp is unchanged.
- R7: A control write with the enable bit 0 clears that channel's pending valid flag at the next edge. An event in that same cycle is not captured.
- R8: `tx_irq` is high for exactly one cycle, the cycle after a transmit capture, and only when `irq_mask` is 1. A receive capture never raises it.
- R9: The channels are independent: events and reads on one channel do not change the other channel's flag or stamp.
- R10: Each control status port reads {valid, enable}, with bit 0 holding the enable and bit 1 holding the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Current time: high word in [63:32], low word in [31:0] |
| tx_evt | input | 1 | Transmit timing event strobe |
| rx_evt | input | 1 | Receive timing event strobe |
| ctl_we | input | 1 | Write strobe for both enable bits |
| ctl_tx_en | input | 1 | Transmit enable value to write |
| ctl_rx_en | input | 1 | Receive enable value to write |
| irq_mask | input | 1 | Allows a transmit capture to pulse tx_irq |
| rd_tx_hi | input | 1 | Transmit high-word read strobe; releases the lock |
| rd_rx_hi | input | 1 | Receive high-word read strobe; releases the lock |
| tx_ctl | output | 2 | Transmit status {valid, enable} |
| rx_ctl | output | 2 | Receive status {valid, enable} |
| tx_lo | output | 32 | Transmit stamp, low word |
| tx_hi | output | 32 | Transmit stamp, high word |
| rx_lo | output | 32 | Receive stamp, low word |
| rx_hi | output | 32 | Receive stamp, high word |
| tx_irq | output | 1 | One-cycle transmit stamp interrupt cause |

## Verification
The bench builds the block with its default word width of 32. This makes the stamps 64 bits wide. Every time value the bench applies carries a distinct seed byte in both words, so a stamp that was wrongly overwritten, or whose words were swapped, shows up as a wrong seed.

The vector walk covers these cases:
- the lock against later events
- release by a high-word read alone
- an event that collides with the releasing read
- the single-cycle interrupt pulse

Directed steps cover reset, disabling with a pending stamp, events while disabled, and a capture with the mask off.

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*WORD_W-1:0] sys_time,
  input  logic                tx_evt,
  input  logic                rx_evt,
  input  logic                ctl_we,
  input  logic                ctl_tx_en,
  input  logic                ctl_rx_en,
  input  logic                irq_mask,
  input  logic                rd_tx_hi,
  input  logic                rd_rx_hi,
  output logic [1:0]          tx_ctl,
  output logic [1:0]          rx_ctl,
  output logic [WORD_W-1:0]   tx_lo,
  output logic [WORD_W-1:0]   tx_hi,
  output logic [WORD_W-1:0]   rx_lo,
  output logic [WORD_W-1:0]   rx_hi,
  output logic                tx_irq
);
  localparam int TW = 2 * WORD_W;
  localparam int NCH = 2;

  logic [NCH-1:0] evt, rd_hi, en_d, en_q, vld_q, cap, kill;
  logic [TW-1:0]  stamp_q [NCH];

  assign evt   = {rx_evt, tx_evt};
  assign rd_hi = {rd_rx_hi, rd_tx_hi};
  assign en_d  = {ctl_rx_en, ctl_tx_en};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign kill[c] = ctl_we & ~en_d[c];
    assign cap[c]  = evt[c] & en_q[c] & ~vld_q[c] & ~rd_hi[c] & ~kill[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[c]    <= 1'b0;
        vld_q[c]   <= 1'b0;
        stamp_q[c] <= '0;
      end else begin
        if (ctl_we) en_q[c] <= en_d[c];
        if (kill[c] || rd_hi[c]) vld_q[c] <= 1'b0;
        else if (cap[c])         vld_q[c] <= 1'b1;
        if (cap[c]) stamp_q[c] <= sys_time;
      end
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[c] && !rd_hi[c] && !kill[c] |=> vld_q[c] && $stable(stamp_q[c])); // R4
    AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] && !vld_q[c] |=> !vld_q[c]); // R2
    AST_HI_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi[c] |=> !vld_q[c]); // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kill[c] |=> !vld_q[c] && !en_q[c]); // R7
    AST_CAPTURE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      evt[c] && en_q[c] && !vld_q[c] && !rd_hi[c] && !kill[c]
      |=> vld_q[c] && stamp_q[c] == $past(sys_time)); // R3
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_irq <= 1'b0;
    else        tx_irq <= cap[0] & irq_mask;
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R8
  AST_IRQ_WITH_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> vld_q[0] || $past(rd_tx_hi) || $past(ctl_we)); // R8

  assign tx_ctl = {vld_q[0], en_q[0]};
  assign rx_ctl = {vld_q[1], en_q[1]};
  assign tx_lo  = stamp_q[0][WORD_W-1:0];
  assign tx_hi  = stamp_q[0][TW-1:WORD_W];
  assign rx_lo  = stamp_q[1][WORD_W-1:0];
  assign rx_hi  = stamp_q[1][TW-1:WORD_W];
endmodule

// File: tb/evt_stamp_capture_test.sv
module evt_stamp_capture_test;
  logic clk = 0, rst_n = 0;
  logic [63:0] sys_time = '0;
  logic tx_evt = 0, rx_evt = 0, ctl_we = 0, ctl_tx_en = 0, ctl_rx_en = 0;
  logic irq_mask = 0, rd_tx_hi = 0, rd_rx_hi = 0;
  logic [1:0] tx_ctl, rx_ctl;
  logic [31:0] tx_lo, tx_hi, rx_lo, rx_hi;
  logic tx_irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  evt_stamp_capture uut (.*);

  // vector: tx_evt rx_evt rd_tx_hi rd_rx_hi | seed | exp txv rxv irq | exp tx seed | exp rx seed
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {4'b1100, 8'h01, 3'b111, 8'h01, 8'h01},  // R3 capture both, R8 irq
    {4'b1000, 8'h02, 3'b110, 8'h01, 8'h01},  // R4 locked
    {4'b0000, 8'h03, 3'b110, 8'h01, 8'h01},  // R4 idle holds
    {4'b0010, 8'h04, 3'b010, 8'h01, 8'h01},  // R5 tx hi read alone
    {4'b1000, 8'h05, 3'b111, 8'h05, 8'h01},  // R5 re-armed, R9 rx held
    {4'b1010, 8'h06, 3'b010, 8'h05, 8'h01},  // R6 collision dropped
    {4'b0001, 8'h07, 3'b000, 8'h05, 8'h01},  // R5 rx hi read
    {4'b0100, 8'h08, 3'b010, 8'h05, 8'h08},  // R8 rx no irq, R9
    {4'b1000, 8'h09, 3'b111, 8'h09, 8'h08},  // R3 again
    {4'b0000, 8'h0A, 3'b110, 8'h09, 8'h08}   // R8 single pulse
  };

  function automatic logic [63:0] mk(input logic [7:0] s);
    return {8'h5A, s, 8'h3C, ~s, 8'hA5, s, s, ~s};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); step;
    rst_n = 1; step;
    chk("R1 tx_ctl", tx_ctl, 0); chk("R1 rx_ctl", rx_ctl, 0);
    chk("R1 stamps", {tx_hi, tx_lo, rx_hi, rx_lo} == 0, 1); chk("R1 irq", tx_irq, 0);

    // R2: events while disabled
    sys_time = mk(8'hEE); tx_evt = 1; rx_evt = 1; step; tx_evt = 0; rx_evt = 0;
    chk("R2 tx_ctl", tx_ctl, 0); chk("R2 rx_ctl", rx_ctl, 0);
    chk("R2 stamp", {tx_hi, tx_lo}, 0);

    ctl_we = 1; ctl_tx_en = 1; ctl_rx_en = 1; irq_mask = 1; step; ctl_we = 0;
    chk("R10 tx_ctl enable bit", tx_ctl, 2'b01);

    for (int i = 0; i < NV; i++) begin
      {tx_evt, rx_evt, rd_tx_hi, rd_rx_hi} = VEC[i][30:27];
      sys_time = mk(VEC[i][26:19]);
      step;
      {tx_evt, rx_evt, rd_tx_hi, rd_rx_hi} = 4'b0;
      chk("R3/R4/R5/R6/R9 tx valid", tx_ctl[1], VEC[i][18]);
      chk("R9 rx valid", rx_ctl[1], VEC[i][17]);
      chk("R8 irq", tx_irq, VEC[i][16]);
      chk("R3 tx stamp", {tx_hi, tx_lo}, mk(VEC[i][15:8]));
      chk("R3 rx stamp", {rx_hi, rx_lo}, mk(VEC[i][7:0]));
    end
    chk("R10 tx_ctl valid+enable", tx_ctl, 2'b11);

    // R7: disable with pending stamp, event same cycle
    ctl_we = 1; ctl_tx_en = 0; ctl_rx_en = 1; tx_evt = 1; sys_time = mk(8'h44);
    step; ctl_we = 0; tx_evt = 0;
    chk("R7 tx_ctl", tx_ctl, 2'b00);
    chk("R7 stamp kept", {tx_hi, tx_lo}, mk(8'h09));
    chk("R9 rx unaffected", rx_ctl, 2'b11);

    // R2: event while disabled after having been enabled
    tx_evt = 1; sys_time = mk(8'h45); step; tx_evt = 0;
    chk("R2 no capture", tx_ctl, 2'b00);
    chk("R2 stamp kept", {tx_hi, tx_lo}, mk(8'h09));

    // R8: mask clear, capture without irq
    ctl_we = 1; ctl_tx_en = 1; irq_mask = 0; step; ctl_we = 0;
    tx_evt = 1; sys_time = mk(8'h46); step; tx_evt = 0;
    chk("R8 masked irq", tx_irq, 0);
    chk("R3 masked capture", {tx_ctl, tx_hi, tx_lo}, {2'b11, mk(8'h46)});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule